// File: doc/BRIEF.md
# Color Bar Byte Pattern Generator

This block produces the payload bytes of one active video line for a test pattern. A one-cycle line-start pulse loads a snapshot of the configuration and starts the line. The block then offers bytes on a valid/ready stream until the programmed line length has been delivered. The snapshot fixes the settings for the whole line, so software may change the configuration inputs while a line is running.

There are two fill modes. In bar mode the line is cut into 1, 2, 4 or 8 bars. Each bar repeats one color byte, and the final bar takes every byte left over. In fixed mode a short block of color bytes (1 to 12 long) is replayed from its first byte across the whole line. The stream follows the usual rules. A byte moves only on a cycle where valid and ready are both high. While ready is low the offered byte and its last flag hold steady. Ready may stay high all the time, and the block then delivers one byte per cycle.

Top module: `cbar_pattern_gen`

## Requirements
- R1: After reset, out_valid stays low until the first line_start pulse.
- R2: On a line_start pulse with line_size N > 0, out_valid rises on the next cycle. Exactly N bytes are delivered, and out_last is high on byte N-1 and only there. out_valid falls after that byte is accepted. If N = 0, no byte is offered.
- R3: While out_valid is high and out_ready is low, out_valid, out_data and out_last keep their values on the next cycle, unless a line_start arrives.
- R4: With fixed_mode = 0, bar_code values 0, 1, 2 and 3 give 1, 2, 4 and 8 bars.
- R5: In bar mode, bar k sends color byte k (colors bits 8k+7:8k) for every one of its bytes. Each bar except the last is bar_size bytes long, and the last bar takes all bytes that remain.
- R6: If the earlier bars already reach line_size, the line ends at line_size and the bars not yet reached are never sent.
- R7: With fixed_mode = 1, byte i of the line equals color byte (i mod B), where B is the effective block size.
- R8: A block_size of 0 is used as 1. Any value above 12 is used as 12.
- R9: A line_start pulse during a line restarts at byte 0, bar 0 and block byte 0.
- R10: All configuration inputs, colors included, are sampled on the line_start pulse. Changes made during a line have no effect until the next pulse.
- R11: In bar mode with bar_size = 0, every byte of the line uses the color of the last bar.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | One-cycle pulse that starts (or restarts) a line |
| fixed_mode | input | 1 | 0 = bar mode, 1 = fixed block mode |
| bar_code | input | 2 | Bar count code: 0,1,2,3 -> 1,2,4,8 bars |
| bar_size | input | 16 | Bytes per bar, for every bar except the last |
| line_size | input | 16 | Bytes in the line |
| block_size | input | 4 | Fixed block length in bytes (1 to 12 are legal) |
| colors | input | 96 | Twelve color bytes, byte k at bits 8k+7:8k |
| out_data | output | 8 | Offered payload byte |
| out_valid | output | 1 | A byte is offered |
| out_ready | input | 1 | Sink accepts the offered byte |
| out_last | output | 1 | Offered byte is the final byte of the line |

## Verification
Each internal counter shows up at the ports in its own way. A wrong position counter moves out_last, or leaves out_valid high past the line length, and this appears on the first line whose length it touches. A wrong bar counter or block index changes out_data at the first bar boundary or block wrap after the fault, which can be only one or two bytes into the line. Stall handling is shown by comparing each held byte with the one offered on the cycle before.

// File: rtl/cbar_pkg.sv
package cbar_pkg;
  typedef enum logic {FILL_BARS = 1'b0, FILL_FIXED = 1'b1} fill_mode_e;

  localparam logic [1:0]  DEF_BAR_CODE  = 2'd3;
  localparam logic [3:0]  DEF_BLOCK     = 4'd3;
  localparam logic [15:0] DEF_LINE_SIZE = 16'd1920;
  localparam logic [15:0] DEF_BAR_SIZE  = 16'd240;
endpackage

// File: rtl/cbar_line_counter.sv
module cbar_line_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] line_len,
  input  logic             take,
  output logic             active,
  output logic             is_last
);
  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] len_q;

  assign is_last = active && (pos_q == len_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      len_q  <= '0;
      active <= 1'b0;
    end else if (start) begin
      pos_q  <= '0;
      len_q  <= line_len;
      active <= (line_len != '0);
    end else if (take && active) begin
      if (is_last) active <= 1'b0;
      else         pos_q  <= pos_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cbar_bar_tracker.sv
module cbar_bar_tracker #(
  parameter int CNT_W = 16,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             take,
  input  logic [CNT_W-1:0] bar_len,
  input  logic [IDX_W-1:0] last_bar,
  output logic [IDX_W-1:0] bar_idx
);
  logic [CNT_W-1:0] in_bar_q;
  logic [CNT_W-1:0] len_q;
  logic [IDX_W-1:0] last_q;
  logic             bar_done;

  assign bar_done = (in_bar_q + CNT_W'(1)) == len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bar_idx  <= '0;
      in_bar_q <= '0;
      len_q    <= '0;
      last_q   <= '0;
    end else if (start) begin
      bar_idx  <= (bar_len == '0) ? last_bar : '0;
      in_bar_q <= '0;
      len_q    <= bar_len;
      last_q   <= last_bar;
    end else if (take && (bar_idx != last_q)) begin
      if (bar_done) begin
        bar_idx  <= bar_idx + IDX_W'(1);
        in_bar_q <= '0;
      end else begin
        in_bar_q <= in_bar_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/cbar_block_cycler.sv
module cbar_block_cycler #(
  parameter int BLK_W     = 4,
  parameter int MAX_BLOCK = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             take,
  input  logic [BLK_W-1:0] block_raw,
  output logic [BLK_W-1:0] blk_idx
);
  localparam logic [BLK_W-1:0] MAX_B = BLK_W'(MAX_BLOCK);

  logic [BLK_W-1:0] eff_now;
  logic [BLK_W-1:0] eff_q;

  always_comb begin
    if (block_raw == '0)        eff_now = BLK_W'(1);
    else if (block_raw > MAX_B) eff_now = MAX_B;
    else                        eff_now = block_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_idx <= '0;
      eff_q   <= BLK_W'(1);
    end else if (start) begin
      blk_idx <= '0;
      eff_q   <= eff_now;
    end else if (take) begin
      if (blk_idx + BLK_W'(1) >= eff_q) blk_idx <= '0;
      else                              blk_idx <= blk_idx + BLK_W'(1);
    end
  end
endmodule

// File: rtl/cbar_pattern_gen.sv
module cbar_pattern_gen #(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 16,
  parameter int CODE_W     = 2,
  parameter int BLK_W      = 4,
  parameter int MAX_BLOCK  = 12,
  parameter int NUM_COLORS = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         line_start,
  input  logic                         fixed_mode,
  input  logic [CODE_W-1:0]            bar_code,
  input  logic [CNT_W-1:0]             bar_size,
  input  logic [CNT_W-1:0]             line_size,
  input  logic [BLK_W-1:0]             block_size,
  input  logic [NUM_COLORS*DATA_W-1:0] colors,
  output logic [DATA_W-1:0]            out_data,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic                         out_last
);
  import cbar_pkg::*;

  localparam int MAX_BARS  = 1 << ((1 << CODE_W) - 1);
  localparam int BAR_IDX_W = (MAX_BARS > 1) ? $clog2(MAX_BARS) : 1;
  localparam int SEL_W     = $clog2(NUM_COLORS);

  fill_mode_e                  mode_q;
  logic [NUM_COLORS*DATA_W-1:0] colors_q;
  logic [DATA_W-1:0]           color_arr [NUM_COLORS];
  logic [BAR_IDX_W-1:0]        last_bar_now;
  logic [BAR_IDX_W-1:0]        bar_idx;
  logic [BLK_W-1:0]            blk_idx;
  logic                        take;
  logic [SEL_W-1:0]            sel;

  assign take = out_valid && out_ready;
  assign last_bar_now = BAR_IDX_W'((32'd1 << bar_code) - 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= FILL_BARS;
      colors_q <= '0;
    end else if (line_start) begin
      mode_q   <= fill_mode_e'(fixed_mode);
      colors_q <= colors;
    end
  end

  for (genvar k = 0; k < NUM_COLORS; k++) begin : g_color
    assign color_arr[k] = colors_q[k*DATA_W +: DATA_W];
  end

  cbar_line_counter #(.CNT_W(CNT_W)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (line_start),
    .line_len (line_size),
    .take     (take),
    .active   (out_valid),
    .is_last  (out_last)
  );

  cbar_bar_tracker #(.CNT_W(CNT_W), .IDX_W(BAR_IDX_W)) u_bar (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (line_start),
    .take     (take),
    .bar_len  (bar_size),
    .last_bar (last_bar_now),
    .bar_idx  (bar_idx)
  );

  cbar_block_cycler #(.BLK_W(BLK_W), .MAX_BLOCK(MAX_BLOCK)) u_blk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (line_start),
    .take      (take),
    .block_raw (block_size),
    .blk_idx   (blk_idx)
  );

  always_comb begin
    if (mode_q == FILL_FIXED) sel = SEL_W'(blk_idx);
    else                      sel = SEL_W'(bar_idx);
  end

  assign out_data = color_arr[sel];
endmodule

// File: rtl/cbar_pattern_gen_chk.sv
module cbar_pattern_gen_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_start,
  input logic [CNT_W-1:0]  line_size,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_last
);
  logic seen_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          seen_start <= 1'b0;
    else if (line_start) seen_start <= 1'b1;
  end

  assert_idle_before_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_start |-> !out_valid);

  assert_start_offers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && line_size != '0) |=> out_valid);

  assert_empty_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && line_size == '0) |=> !out_valid);

  assert_end_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last && !line_start) |=> !out_valid);

  assert_hold_on_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !line_start) |=>
      (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

bind cbar_pattern_gen cbar_pattern_gen_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_start (line_start),
  .line_size  (line_size),
  .out_data   (out_data),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_last   (out_last)
);

// File: tb/cbar_pattern_gen_bench.sv
module cbar_pattern_gen_bench;
  import cbar_pkg::*;

  typedef struct packed {
    logic        fixed;
    logic [1:0]  code;
    logic [15:0] bar;
    logic [15:0] line;
    logic [3:0]  blk;
    logic        stall;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, DEF_BAR_CODE, DEF_BAR_SIZE, DEF_LINE_SIZE, DEF_BLOCK, 1'b0}, // R4 R5 defaults
    '{1'b0, 2'd0, 16'd5,  16'd20, 4'd3,  1'b1}, // R4 one bar
    '{1'b0, 2'd1, 16'd7,  16'd20, 4'd3,  1'b1}, // R5 last bar absorbs
    '{1'b0, 2'd2, 16'd4,  16'd23, 4'd3,  1'b0}, // R4 four bars
    '{1'b0, 2'd3, 16'd10, 16'd25, 4'd3,  1'b1}, // R6 unused bars skipped
    '{1'b1, 2'd3, 16'd240,16'd30, 4'd3,  1'b1}, // R7 fixed block 3
    '{1'b1, 2'd0, 16'd0,  16'd25, 4'd0,  1'b0}, // R8 zero block
    '{1'b1, 2'd0, 16'd0,  16'd40, 4'd15, 1'b1}, // R8 clamp to 12
    '{1'b1, 2'd0, 16'd0,  16'd29, 4'd12, 1'b0}, // R7 full block
    '{1'b0, 2'd3, 16'd0,  16'd17, 4'd3,  1'b0}, // R11 zero bar size
    '{1'b0, 2'd3, 16'd1,  16'd9,  4'd3,  1'b1}, // R5 one-byte bars
    '{1'b0, 2'd2, 16'd3,  16'd1,  4'd3,  1'b0}  // R2 single byte line
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0;
  logic        fixed_mode = 1'b0;
  logic [1:0]  bar_code = '0;
  logic [15:0] bar_size = '0;
  logic [15:0] line_size = '0;
  logic [3:0]  block_size = '0;
  logic [95:0] colors = '0;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_last;

  localparam logic [95:0] COLS = {8'h99, 8'h44, 8'h22, 8'h11,
                                  8'h80, 8'h0F, 8'hCC, 8'h55, 8'h7F, 8'hF0, 8'h33, 8'hAA};

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  cbar_pattern_gen u_cbar_pattern_gen (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .fixed_mode(fixed_mode),
    .bar_code(bar_code), .bar_size(bar_size), .line_size(line_size),
    .block_size(block_size), .colors(colors), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(vec_t v, int i);
    int b, nb, bar;
    if (v.fixed) begin
      b = (v.blk == 0) ? 1 : ((v.blk > 12) ? 12 : int'(v.blk));
      return COLS[(i % b)*8 +: 8];
    end
    nb = 1 << v.code;
    if (v.bar == 0) bar = nb - 1;
    else begin
      bar = i / int'(v.bar);
      if (bar > nb - 1) bar = nb - 1;
    end
    return COLS[bar*8 +: 8];
  endfunction

  task automatic apply_cfg(vec_t v);
    fixed_mode = v.fixed; bar_code = v.code; bar_size = v.bar;
    line_size = v.line; block_size = v.blk; colors = COLS;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    out_ready = 1'b0;
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
  endtask

  // Runs one full line; config inputs are scrambled after the start pulse (R10).
  task automatic run_line(int vi, string tag);
    vec_t v = VECS[vi];
    int got = 0, bad_data = 0, bad_last = 0, bad_hold = 0, first_bad = -1;
    int act_b = 0, exp_b = 0, guard = 0;
    bit done = 0, pv = 0, pr = 0;
    logic [7:0] pd = '0;
    apply_cfg(v);
    pulse_start();
    fixed_mode = ~v.fixed; bar_code = ~v.code; bar_size = v.bar + 16'd3;
    line_size = v.line + 16'd5; block_size = v.blk ^ 4'd5; colors = ~COLS;
    while (!done && guard < int'(v.line) * 4 + 20) begin
      guard++;
      if (pv && !pr && (!out_valid || out_data != pd)) bad_hold++;
      out_ready = v.stall ? (guard % 3 != 0) : 1'b1;
      if (out_valid && out_ready) begin
        if (out_data != exp_byte(v, got)) begin
          bad_data++;
          if (first_bad < 0) begin first_bad = got; act_b = out_data; exp_b = exp_byte(v, got); end
        end
        if (out_last != (got == int'(v.line) - 1)) bad_last++;
        got++;
        if (out_last) done = 1;
      end
      pv = out_valid; pr = out_ready; pd = out_data;
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(bad_data == 0, {tag, " R5/R7/R10 byte values"}, act_b, exp_b);
    check(got == int'(v.line) && !out_valid, {tag, " R2/R6 byte count"}, got, v.line);
    check(bad_last == 0, {tag, " R2 last flag"}, bad_last, 0);
    if (v.stall) check(bad_hold == 0, {tag, " R3 hold on stall"}, bad_hold, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid, "R1 reset idle", out_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!out_valid, "R1 idle before start", out_valid, 0);

    for (int i = 0; i < NV; i++) run_line(i, $sformatf("vec%0d", i));

    // R2: zero-length line offers nothing
    apply_cfg(VECS[1]);
    line_size = 16'd0;
    pulse_start();
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(!out_valid, "R2 empty line", out_valid, 0);
    out_ready = 1'b0;

    // R9: restart in mid-line, fixed mode and bar mode
    for (int t = 0; t < 2; t++) begin
      int vi = (t == 0) ? 5 : 3;
      apply_cfg(VECS[vi]);
      pulse_start();
      out_ready = 1'b1;
      repeat (5) @(negedge clk);
      out_ready = 1'b0;
      check(out_valid && out_data != exp_byte(VECS[vi], 0) || out_data == exp_byte(VECS[vi], 0),
            "R9 mid-line state", out_data, out_data);
      run_line(vi, "R9 restart");
      apply_cfg(VECS[vi]);
      pulse_start();
      check(out_valid && out_data == exp_byte(VECS[vi], 0), "R9 first byte after restart",
            out_data, exp_byte(VECS[vi], 0));
    end
    out_ready = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule